// File: doc/BRIEF.md
# Variable-Length Instruction Decoder

This block takes a window of up to six instruction bytes fetched at the current program counter and splits out the fields of one instruction. The first byte sets everything else. Its high nibble is the instruction class and its low nibble is the function code. Together they fix the instruction length and decide whether a register byte or a 32-bit constant follows. The decoder also reports whether the instruction is legal and gives the address of the next instruction.

A fetch stage presents the window on `fetch_win` with `fetch_pc` and pulses `dec_en`. Byte 0, the byte at the PC, occupies bits [7:0], and byte k occupies bits [8k+7:8k]. One clock later the decoded fields appear on the registered outputs with `out_vld` high. The outputs keep their values while `dec_en` is low. Register selectors use the value 8 to mean "no register". Constants are read little-endian, so the lowest-addressed byte is least significant.

Top module: `insn_len_decoder`

## Requirements
- R1: While reset is active and afterwards until the first decode, out_vld is 0; out_icode, out_ifun, out_valc, out_len, out_valp and out_bad are 0; out_ra and out_rb are 8.
- R2: A decode started with dec_en high shows its results on the outputs after the next rising clock edge, with out_vld high. Each cycle in which dec_en is low leaves out_vld 0 after the next edge and leaves every other output unchanged.
- R3: out_icode is bits [7:4] of byte 0 and out_ifun is bits [3:0] of byte 0, whether or not the instruction is legal.
- R4: For a legal instruction out_len depends only on the class. Classes 0 (no-op) and 1 (halt) give 1. Classes 2 (register move) and 6 (arithmetic/logic) give 2. Class 7 (jump) gives 5. Classes 3 (immediate load), 4 (store) and 5 (load) give 6.
- R5: For legal classes 2 to 6, out_ra is bits [7:4] of byte 1 and out_rb is bits [3:0] of byte 1. All other instructions report 8 on both.
- R6: For classes 3, 4 and 5, out_valc is bytes 2 to 5 taken little-endian, with byte 2 as least significant. For a jump it is bytes 1 to 4 taken the same way, giving the absolute target. Every other instruction gives 0. Example: 50 15 f4 ff ff ff gives 0xfffffff4.
- R7: out_valp equals fetch_pc plus out_len, modulo 2^32.
- R8: out_bad is 1 when any of these holds: the class is 8 to 15; the class is 0 to 5 with a nonzero function code; the class is 6 with a function code above 3; the class is 7 with a function code above 6.
- R9: When out_bad is 1, out_len is 1, out_ra and out_rb are 8 and out_valc is 0.
- R10: Bytes 30 82 cd ab 00 00 decode to class 3 with out_ra 8, out_rb 2, out_valc 0x0000abcd and length 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dec_en | input | 1 | Decode the present window this cycle |
| fetch_win | input | 48 | Instruction bytes, byte 0 in bits [7:0] |
| fetch_pc | input | 32 | Address of byte 0 |
| out_vld | output | 1 | Outputs hold a fresh decode |
| out_icode | output | 4 | Instruction class |
| out_ifun | output | 4 | Function code |
| out_ra | output | 4 | First register selector, 8 when absent |
| out_rb | output | 4 | Second register selector, 8 when absent |
| out_valc | output | 32 | Constant field, 0 when absent |
| out_len | output | 3 | Instruction length in bytes |
| out_valp | output | 32 | Address of the following instruction |
| out_bad | output | 1 | Illegal instruction |

## Verification
The properties assume that `dec_en` is a clean level sampled once per edge and that `fetch_win` and `fetch_pc` are steady around every edge at which `dec_en` is high. They make no assumption about byte values, so any class and function code must give a length from 1 to 6 and a consistent next address. The stimulus changes inputs only on falling edges and draws classes from all sixteen values, with mostly legal function codes, so that illegal cases also occur. PC values near the top of the address space are included so that the wrap in the next-address sum is exercised.

// File: rtl/ild_pkg.sv
package ild_pkg;
  localparam logic [3:0] NO_REG  = 4'h8;
  localparam logic [3:0] C_NOP   = 4'h0;
  localparam logic [3:0] C_HALT  = 4'h1;
  localparam logic [3:0] C_RRMV  = 4'h2;
  localparam logic [3:0] C_IRMV  = 4'h3;
  localparam logic [3:0] C_RMMV  = 4'h4;
  localparam logic [3:0] C_MRMV  = 4'h5;
  localparam logic [3:0] C_ALU   = 4'h6;
  localparam logic [3:0] C_JMP   = 4'h7;
  localparam logic [3:0] ALU_FMAX = 4'h3;
  localparam logic [3:0] JMP_FMAX = 4'h6;

  typedef struct packed {
    logic       bad;
    logic       has_reg;
    logic       has_const;
    logic       const_at1;
  } shape_t;
endpackage

// File: rtl/ild_classify.sv
module ild_classify
  import ild_pkg::*;
#(
  parameter int LEN_W = 3
) (
  input  logic [3:0]       icode,
  input  logic [3:0]       ifun,
  output shape_t           shape,
  output logic [LEN_W-1:0] len
);
  logic [LEN_W-1:0] raw_len;
  shape_t           raw;

  always_comb begin
    raw     = '0;
    raw_len = LEN_W'(1);
    unique case (icode)
      C_NOP, C_HALT: begin
        raw.bad = (ifun != 4'h0);
      end
      C_RRMV: begin
        raw_len     = LEN_W'(2);
        raw.has_reg = 1'b1;
        raw.bad     = (ifun != 4'h0);
      end
      C_ALU: begin
        raw_len     = LEN_W'(2);
        raw.has_reg = 1'b1;
        raw.bad     = (ifun > ALU_FMAX);
      end
      C_IRMV, C_RMMV, C_MRMV: begin
        raw_len       = LEN_W'(6);
        raw.has_reg   = 1'b1;
        raw.has_const = 1'b1;
        raw.bad       = (ifun != 4'h0);
      end
      C_JMP: begin
        raw_len       = LEN_W'(5);
        raw.has_const = 1'b1;
        raw.const_at1 = 1'b1;
        raw.bad       = (ifun > JMP_FMAX);
      end
      default: begin
        raw.bad = 1'b1;
      end
    endcase
  end

  always_comb begin
    if (raw.bad) begin
      shape = '{bad: 1'b1, has_reg: 1'b0, has_const: 1'b0, const_at1: 1'b0};
      len   = LEN_W'(1);
    end else begin
      shape = raw;
      len   = raw_len;
    end
  end
endmodule

// File: rtl/ild_const.sv
module ild_const #(
  parameter int WORD_W = 32,
  parameter int WIN_BYTES = 6
) (
  input  logic [WIN_BYTES*8-1:0] win,
  input  logic                   has_const,
  input  logic                   const_at1,
  output logic [WORD_W-1:0]      valc
);
  localparam int CBYTES = WORD_W / 8;

  for (genvar k = 0; k < CBYTES; k++) begin : g_byte
    logic [7:0] from1;
    logic [7:0] from2;
    assign from1 = win[8*(1+k) +: 8];
    assign from2 = win[8*(2+k) +: 8];
    assign valc[8*k +: 8] = !has_const ? 8'h00 : (const_at1 ? from1 : from2);
  end
endmodule

// File: rtl/ild_regsplit.sv
module ild_regsplit
  import ild_pkg::*;
(
  input  logic [7:0] reg_byte,
  input  logic       present,
  output logic [3:0] ra,
  output logic [3:0] rb
);
  always_comb begin
    if (present) begin
      ra = reg_byte[7:4];
      rb = reg_byte[3:0];
    end else begin
      ra = NO_REG;
      rb = NO_REG;
    end
  end
endmodule

// File: rtl/insn_len_decoder.sv
module insn_len_decoder
  import ild_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int WORD_W = 32,
  parameter int WIN_BYTES = 2 + WORD_W/8,
  parameter int LEN_W = $clog2(WIN_BYTES + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   dec_en,
  input  logic [WIN_BYTES*8-1:0] fetch_win,
  input  logic [ADDR_W-1:0]      fetch_pc,
  output logic                   out_vld,
  output logic [3:0]             out_icode,
  output logic [3:0]             out_ifun,
  output logic [3:0]             out_ra,
  output logic [3:0]             out_rb,
  output logic [WORD_W-1:0]      out_valc,
  output logic [LEN_W-1:0]       out_len,
  output logic [ADDR_W-1:0]      out_valp,
  output logic                   out_bad
);
  logic [3:0]        d_icode, d_ifun, d_ra, d_rb;
  shape_t            d_shape;
  logic [LEN_W-1:0]  d_len;
  logic [WORD_W-1:0] d_valc;
  logic [ADDR_W-1:0] d_valp;

  assign d_icode = fetch_win[7:4];
  assign d_ifun  = fetch_win[3:0];

  ild_classify #(.LEN_W(LEN_W)) u_cls (
    .icode (d_icode),
    .ifun  (d_ifun),
    .shape (d_shape),
    .len   (d_len)
  );

  ild_regsplit u_reg (
    .reg_byte (fetch_win[15:8]),
    .present  (d_shape.has_reg),
    .ra       (d_ra),
    .rb       (d_rb)
  );

  ild_const #(.WORD_W(WORD_W), .WIN_BYTES(WIN_BYTES)) u_const (
    .win       (fetch_win),
    .has_const (d_shape.has_const),
    .const_at1 (d_shape.const_at1),
    .valc      (d_valc)
  );

  assign d_valp = fetch_pc + ADDR_W'(d_len);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_vld <= 1'b0;
    end else begin
      out_vld <= dec_en;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_icode <= 4'h0;
      out_ifun  <= 4'h0;
      out_ra    <= NO_REG;
      out_rb    <= NO_REG;
      out_valc  <= '0;
      out_len   <= '0;
      out_valp  <= '0;
      out_bad   <= 1'b0;
    end else if (dec_en) begin
      out_icode <= d_icode;
      out_ifun  <= d_ifun;
      out_ra    <= d_ra;
      out_rb    <= d_rb;
      out_valc  <= d_valc;
      out_len   <= d_len;
      out_valp  <= d_valp;
      out_bad   <= d_shape.bad;
    end
  end
endmodule

// File: rtl/ild_sva.sv
module ild_sva #(
  parameter int ADDR_W = 32,
  parameter int WORD_W = 32,
  parameter int WIN_BYTES = 6,
  parameter int LEN_W = 3
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   dec_en,
  input logic [WIN_BYTES*8-1:0] fetch_win,
  input logic [ADDR_W-1:0]      fetch_pc,
  input logic                   out_vld,
  input logic [3:0]             out_icode,
  input logic [3:0]             out_ifun,
  input logic [3:0]             out_ra,
  input logic [3:0]             out_rb,
  input logic [WORD_W-1:0]      out_valc,
  input logic [LEN_W-1:0]       out_len,
  input logic [ADDR_W-1:0]      out_valp,
  input logic                   out_bad
);
  a_r2_vld_rise: assert property (@(posedge clk) disable iff (!rst_n)
    dec_en |=> out_vld);

  a_r2_vld_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_en |=> !out_vld);

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_en |=> ($stable(out_valp) && $stable(out_icode) && $stable(out_valc)
                 && $stable(out_len) && $stable(out_bad)));

  a_r3_fields: assert property (@(posedge clk) disable iff (!rst_n)
    dec_en |=> (out_icode == $past(fetch_win[7:4]) && out_ifun == $past(fetch_win[3:0])));

  a_r4_len_range: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> (out_len >= LEN_W'(1) && out_len <= LEN_W'(WIN_BYTES)));

  a_r7_next_pc: assert property (@(posedge clk) disable iff (!rst_n)
    dec_en |=> (out_valp == $past(fetch_pc) + ADDR_W'(out_len)));

  a_r8_high_class: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && out_icode[3]) |-> out_bad);

  a_r9_bad_shape: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && out_bad) |-> (out_len == LEN_W'(1) && out_ra == 4'h8
                              && out_rb == 4'h8 && out_valc == '0));
endmodule

bind insn_len_decoder ild_sva #(
  .ADDR_W(ADDR_W), .WORD_W(WORD_W), .WIN_BYTES(WIN_BYTES), .LEN_W(LEN_W)
) u_ild_sva (
  .clk(clk), .rst_n(rst_n), .dec_en(dec_en), .fetch_win(fetch_win),
  .fetch_pc(fetch_pc), .out_vld(out_vld), .out_icode(out_icode),
  .out_ifun(out_ifun), .out_ra(out_ra), .out_rb(out_rb),
  .out_valc(out_valc), .out_len(out_len), .out_valp(out_valp),
  .out_bad(out_bad)
);

// File: tb/test_insn_len_decoder.sv
`timescale 1ns/1ps
module test_insn_len_decoder;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        dec_en;
  logic [47:0] fetch_win;
  logic [31:0] fetch_pc;
  logic        out_vld;
  logic [3:0]  out_icode, out_ifun, out_ra, out_rb;
  logic [31:0] out_valc;
  logic [2:0]  out_len;
  logic [31:0] out_valp;
  logic        out_bad;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  logic [3:0]  e_icode, e_ifun, e_ra, e_rb;
  logic [31:0] e_valc, e_valp;
  logic [2:0]  e_len;
  logic        e_bad;

  always #10 clk = ~clk;

  insn_len_decoder i_insn_len_decoder (
    .clk(clk), .rst_n(rst_n), .dec_en(dec_en), .fetch_win(fetch_win),
    .fetch_pc(fetch_pc), .out_vld(out_vld), .out_icode(out_icode),
    .out_ifun(out_ifun), .out_ra(out_ra), .out_rb(out_rb),
    .out_valc(out_valc), .out_len(out_len), .out_valp(out_valp),
    .out_bad(out_bad)
  );

  function automatic logic [7:0] byt(input logic [47:0] w, input int k);
    return w[8*k +: 8];
  endfunction

  task automatic model(input logic [47:0] w, input logic [31:0] pc);
    logic [3:0] ic, fn;
    bit hreg, hc, at1;
    ic = w[7:4];
    fn = w[3:0];
    e_icode = ic;
    e_ifun  = fn;
    hreg = 0; hc = 0; at1 = 0;
    case (ic)
      4'h0, 4'h1: begin e_len = 3'd1; e_bad = (fn != 0); end
      4'h2:       begin e_len = 3'd2; e_bad = (fn != 0); hreg = 1; end
      4'h6:       begin e_len = 3'd2; e_bad = (fn > 3);  hreg = 1; end
      4'h3, 4'h4, 4'h5: begin e_len = 3'd6; e_bad = (fn != 0); hreg = 1; hc = 1; end
      4'h7:       begin e_len = 3'd5; e_bad = (fn > 6);  hc = 1; at1 = 1; end
      default:    begin e_len = 3'd1; e_bad = 1'b1; end
    endcase
    if (e_bad) begin e_len = 3'd1; hreg = 0; hc = 0; end
    e_ra = hreg ? byt(w, 1) >> 4 : 4'h8;
    e_rb = hreg ? byt(w, 1) & 8'h0f : 4'h8;
    if (!hc)      e_valc = 32'h0;
    else if (at1) e_valc = {byt(w, 4), byt(w, 3), byt(w, 2), byt(w, 1)};
    else          e_valc = {byt(w, 5), byt(w, 4), byt(w, 3), byt(w, 2)};
    e_valp = pc + {29'd0, e_len};
  endtask

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    chk("R2", {tag, " vld"}, {31'd0, out_vld}, 32'd1);
    chk("R3", {tag, " icode"}, {28'd0, out_icode}, {28'd0, e_icode});
    chk("R3", {tag, " ifun"}, {28'd0, out_ifun}, {28'd0, e_ifun});
    chk("R4", {tag, " len"}, {29'd0, out_len}, {29'd0, e_len});
    chk("R5", {tag, " ra"}, {28'd0, out_ra}, {28'd0, e_ra});
    chk("R5", {tag, " rb"}, {28'd0, out_rb}, {28'd0, e_rb});
    chk("R6", {tag, " valc"}, out_valc, e_valc);
    chk("R7", {tag, " valp"}, out_valp, e_valp);
    chk("R8", {tag, " bad"}, {31'd0, out_bad}, {31'd0, e_bad});
  endtask

  task automatic decode(input logic [47:0] w, input logic [31:0] pc, input string tag);
    @(negedge clk);
    dec_en = 1'b1; fetch_win = w; fetch_pc = pc;
    model(w, pc);
    @(negedge clk);
    dec_en = 1'b0;
    check_all(tag);
  endtask

  task automatic idle_check();
    fetch_win = {$urandom, 16'(($urandom))};
    fetch_pc  = $urandom;
    @(negedge clk);
    chk("R2", "idle vld", {31'd0, out_vld}, 32'd0);
    chk("R2", "idle valp hold", out_valp, e_valp);
    chk("R2", "idle valc hold", out_valc, e_valc);
    chk("R2", "idle len hold", {29'd0, out_len}, {29'd0, e_len});
  endtask

  function automatic logic [47:0] rand_win();
    logic [47:0] w;
    int r;
    logic [3:0] ic, fn;
    w = {$urandom, 16'($urandom)};
    r = $urandom % 20;
    ic = (r < 15) ? 4'(r % 8) : 4'(8 + $urandom % 8);
    if (($urandom % 5) == 0) fn = 4'($urandom);
    else if (ic == 4'h6) fn = 4'($urandom % 4);
    else if (ic == 4'h7) fn = 4'($urandom % 7);
    else fn = 4'h0;
    w[7:0] = {ic, fn};
    return w;
  endfunction

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; dec_en = 1'b0; fetch_win = '0; fetch_pc = '0;
    repeat (3) @(negedge clk);
    // R1 reset values
    chk("R1", "vld", {31'd0, out_vld}, 32'd0);
    chk("R1", "ra", {28'd0, out_ra}, 32'd8);
    chk("R1", "rb", {28'd0, out_rb}, 32'd8);
    chk("R1", "valc", out_valc, 32'd0);
    chk("R1", "len", {29'd0, out_len}, 32'd0);
    chk("R1", "valp", out_valp, 32'd0);
    chk("R1", "bad", {31'd0, out_bad}, 32'd0);
    rst_n = 1'b1;

    // R10 immediate load example: 30 82 cd ab 00 00
    decode(48'h0000_abcd_8230, 32'h0000_0100, "R10 irmv");
    chk("R10", "rb", {28'd0, out_rb}, 32'd2);
    chk("R10", "valc", out_valc, 32'h0000abcd);
    // R6 load with negative displacement: 50 15 f4 ff ff ff
    decode(48'hffff_fff4_1550, 32'h0000_0057, "R6 mrmv");
    chk("R6", "disp -12", out_valc, 32'hffff_fff4);
    // R6 jump, absolute target: 74 57 00 00 00
    decode(48'h00_0000_0057_74, 32'h0000_006f, "R6 jne");
    chk("R6", "jump target", out_valc, 32'h0000_0057);
    // R4 single byte forms
    decode(48'h0, 32'h10, "R4 nop");
    decode(48'h10, 32'h11, "R4 halt");
    // R8 / R9 illegal forms
    decode(48'hffff_ffff_ff67, 32'h20, "R8 alu fn7");
    chk("R9", "bad len", {29'd0, out_len}, 32'd1);
    decode(48'hffff_ffff_ff77, 32'h20, "R8 jmp fn7");
    decode(48'hffff_ffff_ff21, 32'h20, "R8 rrmv fn1");
    decode(48'h1234_5678_9a_c0, 32'h20, "R8 class c");
    chk("R9", "bad ra", {28'd0, out_ra}, 32'd8);
    // R7 wrap at top of address space
    decode(48'h0000_0000_1240, 32'hffff_fffe, "R7 wrap");
    chk("R7", "wrapped valp", out_valp, 32'h0000_0004);
    // R2 hold while idle
    idle_check();
    idle_check();

    for (int i = 0; i < 600; i++) begin
      decode(rand_win(), $urandom, "rand");
      if ((i % 7) == 0) idle_check();
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule